// File: doc/BRIEF.md
# SCL Clock Divider

This block turns a fast system clock into the serial clock level for an I2C master. A programmable prescaler first divides the system clock down to a module tick. Two phase counters, one for the low half of SCL and one for the high half, then count module ticks. Each half is lengthened by a fixed extension of 7, 6 or 5 ticks, and the prescaler value picks which. A build option fixes the extension at 6 for every prescaler value.

The bit engine that uses the block reads the SCL level request. It also reads two single-cycle strobes, one at each phase boundary, and uses them to time data changes and sampling. While the run enable is low the block is idle, SCL is requested high, and new divider values can be set up. Values that change while the block runs are only taken at the start of the next full SCL period, so a period is never cut short or mixed.

Top module: `scl_divgen`

## Requirements
- R1: After reset, `scl_req` is 1 and both `rise_stb` and `fall_stb` are 0.
- R2: While `run_en` is 0, `scl_req` stays 1 and neither strobe fires. Clearing `run_en` during a run returns the block to that idle state at the next clock edge.
- R3: On the first clock edge that sees `run_en` at 1 after idle, `scl_req` goes to 0 and `fall_stb` is 1 for that one cycle.
- R4: The low phase lasts (low_cnt + d) × (psc_val + 1) system clock cycles.
- R5: The high phase lasts (high_cnt + d) × (psc_val + 1) system clock cycles. After it, the low phase starts again.
- R6: With FORCE_D6 = 0, the extension d is 7 when psc_val is 0, 6 when psc_val is 1, and 5 when psc_val is 2 or more.
- R7: With FORCE_D6 = 1, d is 6 for every psc_val.
- R8: `rise_stb` is high for exactly one cycle, the first cycle of each high phase. `fall_stb` is high for exactly one cycle, the first cycle of each low phase. The two are never high together.
- R9: Changes to psc_val, low_cnt or high_cnt during a run do not alter the current period. They take effect from the next low phase.
- R10: Counts of zero are legal. With low_cnt = high_cnt = 0, each phase lasts d × (psc_val + 1) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Releases the divider from its idle hold |
| psc_val | input | 16 | Prescaler value; the module tick is clk / (psc_val + 1) |
| low_cnt | input | 16 | Low-phase count in module ticks, before extension |
| high_cnt | input | 16 | High-phase count in module ticks, before extension |
| scl_req | output | 1 | Requested SCL level |
| rise_stb | output | 1 | One-cycle pulse on the first cycle of a high phase |
| fall_stb | output | 1 | One-cycle pulse on the first cycle of a low phase |

## Verification
Two functions can land on the same clock edge: the end of the high phase and the reload of the divider values from the ports. The bench provokes this by writing a new low count in the very cycle the fall strobe fires, since the reload has just happened on that edge. It then judges the result by timing phases. The low phase in progress and the high phase that follows must keep the old lengths, and only the next low phase may show the new one. Dropping the enable in the middle of a phase gives a second collision, between the stop and an ongoing count, and is judged by the level and strobes one cycle later.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
    localparam int unsigned EXT_W = 3;

    function automatic logic [EXT_W-1:0] phase_ext(input logic psc_is0,
                                                   input logic psc_is1,
                                                   input bit   force6);
        if (force6)       return EXT_W'(6);
        else if (psc_is0) return EXT_W'(7);
        else if (psc_is1) return EXT_W'(6);
        else              return EXT_W'(5);
    endfunction
endpackage

// File: rtl/scl_psc_tick.sv
module scl_psc_tick #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CNT_W-1:0] psc_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } psc_st_t;

    psc_st_t st_d, st_q;

    assign tick_o = run_i && (st_q.cnt == psc_i);

    always_comb begin
        st_d = st_q;
        if (!run_i)      st_d.cnt = '0;
        else if (tick_o) st_d.cnt = '0;
        else             st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (st_q.cnt <= psc_i));
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq #(
    parameter int unsigned LEN_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic [LEN_W-1:0] low_len_i,
    input  logic [LEN_W-1:0] high_len_i,
    output logic             running_o,
    output logic             scl_o,
    output logic             rise_o,
    output logic             fall_o,
    output logic             period_end_o
);
    typedef struct packed {
        logic             running;
        logic             high;
        logic [LEN_W-1:0] cnt;
        logic             rise;
        logic             fall;
    } seq_st_t;

    seq_st_t          st_d, st_q;
    logic [LEN_W-1:0] cur_len;
    logic             last_tick;

    assign cur_len      = st_q.high ? high_len_i : low_len_i;
    assign last_tick    = (st_q.cnt == cur_len - 1'b1);
    assign period_end_o = st_q.running && en_i && tick_i && st_q.high && last_tick;

    always_comb begin
        st_d      = st_q;
        st_d.rise = 1'b0;
        st_d.fall = 1'b0;
        if (!en_i) begin
            st_d.running = 1'b0;
            st_d.high    = 1'b1;
            st_d.cnt     = '0;
        end else if (!st_q.running) begin
            st_d.running = 1'b1;
            st_d.high    = 1'b0;
            st_d.cnt     = '0;
            st_d.fall    = 1'b1;
        end else if (tick_i) begin
            if (last_tick) begin
                st_d.cnt  = '0;
                st_d.high = !st_q.high;
                st_d.rise = !st_q.high;
                st_d.fall = st_q.high;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{running: 1'b0, high: 1'b1, cnt: '0, rise: 1'b0, fall: 1'b0};
        else        st_q <= st_d;
    end

    assign running_o = st_q.running;
    assign scl_o     = st_q.high;
    assign rise_o    = st_q.rise;
    assign fall_o    = st_q.fall;

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_o, fall_o}));
    // R8
    fall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> !scl_o);
    // R8
    rise_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> scl_o);
    // R2
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (scl_o && !rise_o && !fall_o));
    // R3
    start_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !running_o) |=> (fall_o && !scl_o));
    // R8
    rise_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && $rose(scl_o)) |-> rise_o);
endmodule

// File: rtl/scl_divgen.sv
module scl_divgen #(
    parameter int unsigned REG_W    = 16,
    parameter bit          FORCE_D6 = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [REG_W-1:0] psc_val,
    input  logic [REG_W-1:0] low_cnt,
    input  logic [REG_W-1:0] high_cnt,
    output logic             scl_req,
    output logic             rise_stb,
    output logic             fall_stb
);
    import scl_div_pkg::*;

    localparam int unsigned LEN_W = REG_W + 1;

    typedef struct packed {
        logic [REG_W-1:0] psc;
        logic [REG_W-1:0] low;
        logic [REG_W-1:0] high;
    } shadow_t;

    shadow_t          sh_d, sh_q;
    logic             running, period_end, tick;
    logic [EXT_W-1:0] ext;
    logic [LEN_W-1:0] low_len, high_len;

    always_comb begin
        sh_d = sh_q;
        if (!running || period_end) begin
            sh_d.psc  = psc_val;
            sh_d.low  = low_cnt;
            sh_d.high = high_cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign ext      = phase_ext(sh_q.psc == '0, sh_q.psc == REG_W'(1), FORCE_D6);
    assign low_len  = LEN_W'(sh_q.low)  + LEN_W'(ext);
    assign high_len = LEN_W'(sh_q.high) + LEN_W'(ext);

    scl_psc_tick #(.CNT_W(REG_W)) i_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (running),
        .psc_i  (sh_q.psc),
        .tick_o (tick)
    );

    scl_phase_seq #(.LEN_W(LEN_W)) i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (run_en),
        .tick_i       (tick),
        .low_len_i    (low_len),
        .high_len_i   (high_len),
        .running_o    (running),
        .scl_o        (scl_req),
        .rise_o       (rise_stb),
        .fall_o       (fall_stb),
        .period_end_o (period_end)
    );

    // R9
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !period_end) |=> $stable(sh_q));
    // R9
    reload_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> fall_stb);
endmodule

// File: tb/test_scl_divgen.sv
module test_scl_divgen;
    localparam int NV = 5;
    // psc, low, high, expected low cycles, expected high cycles (default build)
    localparam int VEC [NV][5] = '{
        '{0, 3, 2, 10,  9},
        '{1, 4, 1, 20, 14},
        '{2, 0, 0, 15, 15},
        '{3, 2, 5, 28, 40},
        '{0, 0, 0,  7,  7}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic [15:0] psc_val = '0, low_cnt = '0, high_cnt = '0;
    logic        scl_a, rise_a, fall_a, scl_b, rise_b, fall_b;
    logic        sel_b = 1'b0;
    logic        scl_m, rise_m, fall_m;
    int          checks = 0, fails = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    scl_divgen i_scl_divgen (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .psc_val(psc_val),
        .low_cnt(low_cnt), .high_cnt(high_cnt),
        .scl_req(scl_a), .rise_stb(rise_a), .fall_stb(fall_a));

    scl_divgen #(.FORCE_D6(1'b1)) i_scl_divgen_d6 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .psc_val(psc_val),
        .low_cnt(low_cnt), .high_cnt(high_cnt),
        .scl_req(scl_b), .rise_stb(rise_b), .fall_stb(fall_b));

    assign scl_m  = sel_b ? scl_b  : scl_a;
    assign rise_m = sel_b ? rise_b : rise_a;
    assign fall_m = sel_b ? fall_b : fall_a;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // counts cycles from the current one until the chosen strobe appears
    task automatic count_to(input bit want_rise, output int n);
        n = 1;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (want_rise ? rise_m : fall_m) return;
            n++;
        end
        n = -1;
    endtask

    task automatic go_idle();
        @(negedge clk);
        run_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // enable, check start, measure one low and one high phase
    task automatic start_and_measure(input string tag, output int lo, output int hi);
        run_en = 1'b1;
        @(negedge clk);
        chk({tag, " R3 scl low at start"}, scl_m, 0);
        chk({tag, " R3 fall strobe at start"}, fall_m, 1);
        count_to(1'b1, lo);
        count_to(1'b0, hi);
    endtask

    initial begin
        int lo, hi, lo2, p, l, h;
        repeat (3) @(negedge clk);
        chk("R1 scl after reset", scl_a, 1);
        chk("R1 strobes after reset", rise_a | fall_a, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table walk, default build then forced extension build
        for (int v = 0; v < NV; v++) begin
            p = VEC[v][0]; l = VEC[v][1]; h = VEC[v][2];
            go_idle();
            psc_val = 16'(p); low_cnt = 16'(l); high_cnt = 16'(h);
            sel_b = 1'b0;
            start_and_measure("R6", lo, hi);
            chk("R4 R6 R10 low length", lo, VEC[v][3]);
            chk("R5 R6 R10 high length", hi, VEC[v][4]);
            go_idle();
            sel_b = 1'b1;
            start_and_measure("R7", lo, hi);
            chk("R7 R4 low length d6", lo, (l + 6) * (p + 1));
            chk("R7 R5 high length d6", hi, (h + 6) * (p + 1));
            sel_b = 1'b0;
        end

        // R8: strobes last one cycle
        go_idle();
        psc_val = 16'd1; low_cnt = 16'd2; high_cnt = 16'd3;
        run_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R8 fall strobe one cycle", fall_a, 0);
        count_to(1'b1, lo);
        @(negedge clk);
        chk("R8 rise strobe one cycle", rise_a, 0);
        chk("R8 scl stays high", scl_a, 1);

        // R2: stop mid phase
        @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        chk("R2 idle level after stop", scl_a, 1);
        lo = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (rise_a || fall_a || !scl_a) lo++;
        end
        chk("R2 no activity while idle", lo, 0);

        // R9: new low count written on the reload cycle waits a period
        psc_val = 16'd0; low_cnt = 16'd3; high_cnt = 16'd2;
        run_en = 1'b1;
        @(negedge clk);
        chk("R9 R3 start", fall_a, 1);
        low_cnt = 16'd10;
        count_to(1'b1, lo);
        count_to(1'b0, hi);
        count_to(1'b1, lo2);
        chk("R9 current low keeps old length", lo, 10);
        chk("R9 current high keeps old length", hi, 9);
        chk("R9 next low uses new length", lo2, 17);

        // R9 boundary: change on the reload cycle itself
        count_to(1'b0, hi);
        low_cnt = 16'd1;
        count_to(1'b1, lo);
        count_to(1'b0, hi);
        count_to(1'b1, lo2);
        chk("R9 low after reload edge", lo, 17);
        chk("R9 following low", lo2, 8);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule